// File: doc/BRIEF.md
# Serial Cyclic Code Polynomial Divider

This block decodes a word of a cyclic code whose words were produced by multiplying the data polynomial by a generator polynomial. The received word arrives one coefficient per clock cycle, highest power of x first. A feedback shift register divides it by the same generator. Each flip-flop stage stands for one power of x. Each XOR stands for a modulo-2 subtraction, which is the same operation as modulo-2 addition.

The code is non-separable: the data cannot be read off by dropping check bits. The block therefore emits the quotient serially as the decoded data. When the last coefficient has been absorbed, the block registers the remainder as a syndrome and raises a one-cycle completion pulse. An error flag is set whenever that syndrome is not zero. Errors are detected but not corrected.

Parameters are the generator degree `DEG`, the generator's low-order coefficients `TAPS` (bit j is the coefficient of x^j; the x^DEG term is implied) and the word length `N`. The data length is N−DEG.

Top module: `cyc_divider`

## Requirements
- R1: A synchronous `clr` forces `q_valid`, `done`, `err` and `syndrome` to zero on the next clock edge and abandons any decode in progress.
- R2: Raising `start` marks the cycle that carries the word's first coefficient, the coefficient of x^(N−1), on `code_in`. The following N−1 cycles carry the lower coefficients in descending order, one per cycle, with no gaps.
- R3: After the edges that absorb coefficients DEG through N−1 (0-based index in the word), `q_valid` is high for exactly one cycle each. `q_bit` then shows the quotient coefficients, highest power first. `q_valid` is low after the first DEG edges of a word.
- R4: After the edge that absorbs the N-th coefficient, `syndrome` holds the remainder of the received polynomial modulo the generator, with bit j the coefficient of x^j.
- R5: `err` is 1 exactly when the registered syndrome is nonzero. A zero syndrome declares the word valid.
- R6: `done` is high for exactly one cycle, namely the cycle after the edge that absorbs the N-th coefficient. That same cycle carries the last quotient bit.
- R7: `syndrome` and `err` keep their values, whatever `code_in` does, until the next decode completes or `clr` is applied.
- R8: A `start` during a decode abandons it. Division restarts from a zero register with the coefficient present in the `start` cycle.
- R9: With generator x^3+x+1 and N=7, the word x^6+x^2+1 (fed as 1,0,0,0,1,0,1) gives quotient x^3+x+1 (emitted as 1,0,1,1) and a zero syndrome. Flipping any single coefficient gives a nonzero syndrome and sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear |
| start | input | 1 | Marks the first coefficient of a word |
| code_in | input | 1 | Serial received coefficient |
| q_bit | output | 1 | Serial quotient coefficient |
| q_valid | output | 1 | Qualifies `q_bit` |
| syndrome | output | DEG | Registered final remainder |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Nonzero syndrome flag |

## Verification
The error-free word x^6+x^2+1 checks that a true codeword gives the expected quotient and a zero syndrome. The seven single-bit corruptions of it check that every isolated error leaves a nonzero remainder. Several arbitrary words, with quotients and remainders from an independent long division in the bench, separate correct feedback taps and quotient timing from designs that only pass codewords. Separate scenarios cover holding the result through idle cycles, a restart in the middle of a word, and a clear in the middle of a word. These show whether state leaks from an abandoned decode.

// File: rtl/cyc_divider.sv
module cyc_divider #(
  parameter int             DEG  = 3,
  parameter logic [DEG-1:0] TAPS = 3'b011,
  parameter int             N    = 7
) (
  input  logic           clk,
  input  logic           clr,
  input  logic           start,
  input  logic           code_in,
  output logic           q_bit,
  output logic           q_valid,
  output logic [DEG-1:0] syndrome,
  output logic           done,
  output logic           err
);
  localparam int CW = $clog2(N + 1);

  logic [DEG-1:0] rem_q, shifted, rem_nxt;
  logic [CW-1:0]  cnt_q, idx;
  logic           busy_q, active, fb;

  assign active  = start | busy_q;
  assign idx     = start ? '0 : cnt_q;
  assign fb      = start ? 1'b0 : rem_q[DEG-1];
  assign shifted = start ? {{(DEG-1){1'b0}}, code_in} : {rem_q[DEG-2:0], code_in};
  assign rem_nxt = shifted ^ (fb ? TAPS : '0);

  always_ff @(posedge clk) begin
    if (clr) begin
      rem_q    <= '0;
      cnt_q    <= '0;
      busy_q   <= 1'b0;
      q_bit    <= 1'b0;
      q_valid  <= 1'b0;
      done     <= 1'b0;
      syndrome <= '0;
      err      <= 1'b0;
    end else begin
      q_valid <= 1'b0;
      done    <= 1'b0;
      if (active) begin
        rem_q   <= rem_nxt;
        q_bit   <= fb;
        q_valid <= (idx >= CW'(DEG));
        if (idx == CW'(N - 1)) begin
          busy_q   <= 1'b0;
          cnt_q    <= '0;
          done     <= 1'b1;
          syndrome <= rem_nxt;
          err      <= |rem_nxt;
        end else begin
          busy_q <= 1'b1;
          cnt_q  <= idx + 1'b1;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (clr) done |=> !done); // R6
  AST_DONE_WITH_LAST_Q: assert property (@(posedge clk) disable iff (clr) done |-> q_valid); // R6
  AST_ERR_MATCHES_SYN: assert property (@(posedge clk) disable iff (clr) done |-> (err == (syndrome != '0))); // R5
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (clr) !done |=> (done || ($stable(syndrome) && $stable(err)))); // R7
  AST_START_NO_Q: assert property (@(posedge clk) disable iff (clr) start |=> !q_valid); // R3
endmodule

// File: tb/cyc_divider_tb_top.sv
module cyc_divider_tb_top;
  localparam int DEG = 3;
  localparam int N   = 7;
  localparam int K   = N - DEG;
  localparam logic [DEG:0] GFULL = 4'b1011;

  logic clk = 1'b0, clr = 1'b1, start = 1'b0, code_in = 1'b0;
  logic q_bit, q_valid, done, err;
  logic [DEG-1:0] syndrome;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  cyc_divider #(.DEG(DEG), .TAPS(GFULL[DEG-1:0]), .N(N)) dut_i (
    .clk(clk), .clr(clr), .start(start), .code_in(code_in),
    .q_bit(q_bit), .q_valid(q_valid), .syndrome(syndrome), .done(done), .err(err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void divide(input logic [N-1:0] v, output logic [K-1:0] q, output logic [DEG-1:0] r);
    logic [N-1:0] w = v;
    q = '0;
    for (int j = N - 1; j >= DEG; j--) begin
      if (w[j]) begin
        w = w ^ (N'(GFULL) << (j - DEG));
        q[j - DEG] = 1'b1;
      end
    end
    r = w[DEG-1:0];
  endfunction

  task automatic run_word(input logic [N-1:0] v, input string tag);
    logic [K-1:0] q;
    logic [DEG-1:0] r;
    divide(v, q, r);
    for (int i = 0; i < N; i++) begin
      start   = (i == 0);
      code_in = v[N-1-i];
      @(negedge clk);
      start = 1'b0;
      chk(q_valid == (i >= DEG), {tag, " R3 q_valid"}, int'(q_valid), int'(i >= DEG));
      if (i >= DEG)
        chk(q_bit == q[N-1-i], {tag, " R3 q_bit"}, int'(q_bit), int'(q[N-1-i]));
      chk(done == (i == N - 1), {tag, " R6 done"}, int'(done), int'(i == N - 1));
    end
    chk(syndrome == r, {tag, " R4 syndrome"}, int'(syndrome), int'(r));
    chk(err == (r != '0), {tag, " R5 err"}, int'(err), int'(r != '0));
  endtask

  task automatic t_reset();
    @(negedge clk); @(negedge clk);
    chk(q_valid == 0 && done == 0, "R1 reset q_valid/done", int'({q_valid, done}), 0);
    chk(syndrome == 0 && err == 0, "R1 reset syndrome/err", int'({err, syndrome}), 0);
    clr = 1'b0;
  endtask

  task automatic t_golden();
    logic [N-1:0] cw = 7'b1000101;
    run_word(cw, "R2 R9 codeword");
    chk(syndrome == 0 && err == 0, "R9 clean syndrome", int'(syndrome), 0);
    for (int b = 0; b < N; b++) begin
      run_word(cw ^ (N'(1) << b), "R9 flip");
      chk(syndrome != 0 && err == 1, "R9 flip detected", int'(syndrome), -1);
    end
  endtask

  task automatic t_patterns();
    logic [N-1:0] pats [5] = '{7'b1111111, 7'b0000001, 7'b1010101, 7'b0110010, 7'b1110000};
    for (int p = 0; p < 5; p++) run_word(pats[p], "R4 pattern");
  endtask

  task automatic t_hold();
    logic [DEG-1:0] s;
    logic e;
    run_word(7'b0110010, "R7 pre");
    s = syndrome; e = err;
    for (int i = 0; i < 6; i++) begin
      code_in = i[0];
      @(negedge clk);
      chk(syndrome == s && err == e && done == 0 && q_valid == 0, "R7 hold", int'(syndrome), int'(s));
    end
  endtask

  task automatic t_restart();
    for (int i = 0; i < 3; i++) begin
      start = (i == 0); code_in = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    run_word(7'b1000101, "R8 restart");
    chk(syndrome == 0 && err == 0, "R8 restart clean", int'(syndrome), 0);
  endtask

  task automatic t_clear();
    run_word(7'b1111111, "R1 pre");
    for (int i = 0; i < 5; i++) begin
      start = (i == 0); code_in = 1'b1;
      @(negedge clk);
    end
    start = 1'b0;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk(syndrome == 0 && err == 0 && q_valid == 0 && done == 0, "R1 mid clear", int'(syndrome), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(done == 0 && q_valid == 0, "R1 no resume", int'({done, q_valid}), 0);
    end
    run_word(7'b0000001, "R1 post");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_golden();
    t_patterns();
    t_hold();
    t_restart();
    t_clear();
    finish_run();
  end
endmodule